// File: doc/BRIEF.md
# Priority-Skewed Shared Branch Direction Table

This block is a branch direction predictor table shared by two hardware threads. One is a real-time thread with the highest priority and the other is a background thread. There is one table with no split by thread. Each entry is a single 3-bit counter. Each thread sees that counter through its own 2-bit window, and the two windows overlap. The priority thread works on the upper pair of bits and the background thread on the lower pair. A step by the priority thread therefore moves the entry twice as far as a step by the background thread, so the priority thread's training governs the prediction state.

A fetch stage presents a PC and a thread number on the lookup port and gets a taken/not-taken prediction back in the same cycle. When a branch resolves, the back end presents the PC, the thread number and the actual outcome on the update port with a valid strobe. The entry changes on the next clock edge.

Top module: `skew_bp_top`

## Requirements
- R1: After reset every entry holds 3'b001, so both threads predict not-taken for every PC.
- R2: The entry is selected by PC bits [9:2] alone; PCs that differ only in bits [1:0] or in bits above 9 share one entry, for lookups and updates alike.
- R3: A lookup with thread 0 (priority) returns bit 2 of the entry; a lookup with thread 1 (background) returns bit 1. The result is combinational from the lookup inputs.
- R4: A priority update treats bits [2:1] as a 2-bit counter: it adds one for taken and subtracts one for not-taken, and bit 0 keeps its value.
- R5: A background update treats bits [1:0] as a 2-bit counter in the same way, and bit 2 keeps its value.
- R6: Both windows saturate: taken at window value 3 and not-taken at window value 0 leave the entry unchanged.
- R7: An update takes effect only when the valid strobe is high, and a lookup sees it from the cycle after the strobe.
- R8: A lookup to the entry that is being updated in the same cycle returns the prediction from before the update.
- R9: Updates from one thread are visible to the other thread through the shared bit 1. For example, priority training from 3'b001 to 3'b011 turns the background prediction to taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | 32 | Lookup PC |
| lk_thr | input | 1 | Lookup thread: 0 priority, 1 background |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| up_valid | input | 1 | Update strobe |
| up_pc | input | 32 | PC of the resolved branch |
| up_thr | input | 1 | Thread of the resolved branch: 0 priority, 1 background |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The assertions assume that the inputs are known (not X) whenever the strobe is high. They also assume that the lookup index and thread are stable across the sampling edge. Nothing stops the two ports from naming the same entry in the same cycle. The commit check therefore compares the registered post-update value with the next lookup only when that lookup hits the entry written on the previous edge. The bench drives every input on the falling edge and holds the strobe low through reset. It deliberately pairs lookups with same-cycle and next-cycle updates to one entry, as well as with aliased PCs.

// File: rtl/skew_bp_pkg.sv
package skew_bp_pkg;

   typedef enum logic {
      THR_PRIO = 1'b0,
      THR_BG   = 1'b1
   } thr_e;

   localparam int NUM_THR  = 2;
   localparam int WIN_W    = 2;

endpackage

// File: rtl/skew_bp_index.sv
module skew_bp_index #(
   parameter int PC_W    = 32,
   parameter int IDX_LSB = 2,
   parameter int IDX_W   = 8
) (
   input  logic [PC_W-1:0]  pc,
   output logic [IDX_W-1:0] idx
);

   localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

   if (IDX_LSB < 1) begin : g_bad_lsb
      $error("skew_bp_index: IDX_LSB must be at least 1");
   end
   if (IDX_MSB >= PC_W - 1) begin : g_bad_span
      $error("skew_bp_index: index field must leave upper PC bits");
   end

   assign idx = pc[IDX_MSB:IDX_LSB];

   logic unused_pc_bits;
   assign unused_pc_bits = ^{pc[PC_W-1:IDX_MSB+1], pc[IDX_LSB-1:0]};

endmodule

// File: rtl/skew_bp_window.sv
module skew_bp_window #(
   parameter int CTR_W = 3,
   parameter int LSB   = 0
) (
   input  logic [CTR_W-1:0] cur,
   input  logic             taken,
   output logic [CTR_W-1:0] nxt
);

   import skew_bp_pkg::*;

   localparam logic [WIN_W-1:0] WIN_MAX = '1;
   localparam logic [WIN_W-1:0] WIN_MIN = '0;

   if (LSB + WIN_W > CTR_W) begin : g_bad_lsb
      $error("skew_bp_window: window exceeds counter width");
   end

   logic [WIN_W-1:0] win, win_nxt;

   always_comb begin
      win = cur[LSB +: WIN_W];
      if (taken) begin
         win_nxt = (win == WIN_MAX) ? win : win + 1'b1;
      end else begin
         win_nxt = (win == WIN_MIN) ? win : win - 1'b1;
      end
      nxt = cur;
      nxt[LSB +: WIN_W] = win_nxt;
   end

endmodule

// File: rtl/skew_bp_table.sv
module skew_bp_table #(
   parameter int               IDX_W   = 8,
   parameter int               CTR_W   = 3,
   parameter logic [CTR_W-1:0] RST_VAL = 3'b001
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_a_idx,
   output logic [CTR_W-1:0] rd_a_val,
   input  logic [IDX_W-1:0] rd_b_idx,
   output logic [CTR_W-1:0] rd_b_val,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [CTR_W-1:0] wr_val
);

   localparam int DEPTH = 1 << IDX_W;

   logic [CTR_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem[i] <= RST_VAL;
         end
      end else if (wr_en) begin
         mem[wr_idx] <= wr_val;
      end
   end

   assign rd_a_val = mem[rd_a_idx];
   assign rd_b_val = mem[rd_b_idx];

endmodule

// File: rtl/skew_bp_top.sv
module skew_bp_top #(
   parameter int               PC_W    = 32,
   parameter int               IDX_LSB = 2,
   parameter int               IDX_W   = 8,
   parameter int               CTR_W   = 3,
   parameter logic [CTR_W-1:0] RST_VAL = 3'b001
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] lk_pc,
   input  logic            lk_thr,
   output logic            lk_taken,
   input  logic            up_valid,
   input  logic [PC_W-1:0] up_pc,
   input  logic            up_thr,
   input  logic            up_taken
);

   import skew_bp_pkg::*;

   localparam int PRIO_LSB = CTR_W - WIN_W;
   localparam int BG_LSB   = 0;

   if (CTR_W != 3) begin : g_bad_ctr
      $error("skew_bp_top: counter must be 3 bits wide");
   end

   logic [IDX_W-1:0] lk_idx, up_idx;
   logic [CTR_W-1:0] lk_val, up_old, up_new;
   logic [CTR_W-1:0] nxt_v [NUM_THR];

   skew_bp_index #(.PC_W(PC_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_lk_idx (
      .pc  (lk_pc),
      .idx (lk_idx)
   );

   skew_bp_index #(.PC_W(PC_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_up_idx (
      .pc  (up_pc),
      .idx (up_idx)
   );

   skew_bp_table #(.IDX_W(IDX_W), .CTR_W(CTR_W), .RST_VAL(RST_VAL)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_a_idx (lk_idx),
      .rd_a_val (lk_val),
      .rd_b_idx (up_idx),
      .rd_b_val (up_old),
      .wr_en    (up_valid),
      .wr_idx   (up_idx),
      .wr_val   (up_new)
   );

   for (genvar t = 0; t < NUM_THR; t++) begin : g_win
      localparam int LSB_T = (t == int'(THR_PRIO)) ? PRIO_LSB : BG_LSB;
      skew_bp_window #(.CTR_W(CTR_W), .LSB(LSB_T)) u_win (
         .cur   (up_old),
         .taken (up_taken),
         .nxt   (nxt_v[t])
      );
   end

   assign up_new   = nxt_v[up_thr];
   assign lk_taken = (lk_thr == THR_PRIO) ? lk_val[PRIO_LSB + 1] : lk_val[BG_LSB + 1];

endmodule

// File: rtl/skew_bp_chk.sv
module skew_bp_chk #(
   parameter int IDX_W = 8,
   parameter int CTR_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [IDX_W-1:0] lk_idx,
   input logic             lk_thr,
   input logic             lk_taken,
   input logic             up_valid,
   input logic             up_thr,
   input logic             up_taken,
   input logic [IDX_W-1:0] up_idx,
   input logic [CTR_W-1:0] up_old,
   input logic [CTR_W-1:0] up_new
);

   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   a_r4_prio_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && !up_thr) |-> (up_new[0] == up_old[0]));

   a_r5_bg_top_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_thr) |-> (up_new[CTR_W-1] == up_old[CTR_W-1]));

   a_r6_prio_sat_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && !up_thr && up_taken && up_old[CTR_W-1 -: 2] == 2'b11)
      |-> (up_new == up_old));

   a_r6_bg_sat_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_thr && !up_taken && up_old[1:0] == 2'b00)
      |-> (up_new == up_old));

   a_r7_commit_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(up_valid) && lk_idx == $past(up_idx) && !lk_thr)
      |-> (lk_taken == $past(up_new[CTR_W-1])));

endmodule

bind skew_bp_top skew_bp_chk #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .lk_idx   (lk_idx),
   .lk_thr   (lk_thr),
   .lk_taken (lk_taken),
   .up_valid (up_valid),
   .up_thr   (up_thr),
   .up_taken (up_taken),
   .up_idx   (up_idx),
   .up_old   (up_old),
   .up_new   (up_new)
);

// File: tb/skew_bp_top_tb.sv
module skew_bp_top_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        lk_thr = 1'b0;
   logic        lk_taken;
   logic        up_valid = 1'b0;
   logic [31:0] up_pc = '0;
   logic        up_thr = 1'b0;
   logic        up_taken = 1'b0;

   always #5 clk = ~clk;

   skew_bp_top u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_pc    (lk_pc),
      .lk_thr   (lk_thr),
      .lk_taken (lk_taken),
      .up_valid (up_valid),
      .up_pc    (up_pc),
      .up_thr   (up_thr),
      .up_taken (up_taken)
   );

   typedef struct {
      logic  exp;
      string tag;
   } item_t;

   item_t q[$];
   int    total = 0;
   int    bad   = 0;
   int    mdl [256];
   bit    done = 1'b0;

   function automatic int eidx(input logic [31:0] pc);
      return int'((pc >> 2) & 32'hFF);
   endfunction

   function automatic logic predict(input int v, input logic thr);
      if (!thr) return (v >= 4);
      return (((v / 2) % 2) == 1);
   endfunction

   function automatic int step(input int v, input logic thr, input logic t);
      int lo;
      if (!thr) begin
         if (t) return (v < 6) ? v + 2 : v;
         return (v >= 2) ? v - 2 : v;
      end
      lo = v % 4;
      if (t) lo = (lo < 3) ? lo + 1 : lo;
      else   lo = (lo > 0) ? lo - 1 : lo;
      return (v - (v % 4)) + lo;
   endfunction

   // driver: one cycle of stimulus, expected lookup result queued
   task automatic cyc(input logic [31:0] lpc, input logic lthr, input bit chk,
                      input string tag, input bit uv, input logic [31:0] upc,
                      input logic uthr, input logic ut);
      item_t it;
      @(negedge clk);
      lk_pc = lpc; lk_thr = lthr;
      up_valid = uv; up_pc = upc; up_thr = uthr; up_taken = ut;
      if (chk) begin
         it.exp = predict(mdl[eidx(lpc)], lthr);
         it.tag = tag;
         q.push_back(it);
      end
      @(posedge clk);
      if (uv) mdl[eidx(upc)] = step(mdl[eidx(upc)], uthr, ut);
   endtask

   task automatic look(input logic [31:0] pc, input logic thr, input string tag);
      cyc(pc, thr, 1'b1, tag, 1'b0, '0, 1'b0, 1'b0);
   endtask

   task automatic upd(input logic [31:0] pc, input logic thr, input logic t);
      cyc('0, 1'b0, 1'b0, "", 1'b1, pc, thr, t);
   endtask

   task automatic both_views(input logic [31:0] pc, input string tag);
      look(pc, 1'b0, tag);
      look(pc, 1'b1, tag);
   endtask

   // monitor: compare outputs well after the falling edge
   initial begin
      item_t it;
      forever begin
         @(negedge clk);
         #3;
         if (q.size() > 0) begin
            it = q.pop_front();
            total++;
            if (lk_taken !== it.exp) begin
               bad++;
               $display("FAIL %s: pc=%h thr=%0d got=%b exp=%b",
                        it.tag, lk_pc, lk_thr, lk_taken, it.exp);
            end
         end
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: got=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) mdl[i] = 1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state, both views not-taken
      both_views(32'h0000_0000, "R1");
      both_views(32'h0000_0040, "R1");
      both_views(32'h0000_03FC, "R1");

      // R4 R9 R3: priority training moves by two, background sees bit 1
      for (int k = 0; k < 4; k++) begin
         upd(32'h0000_0040, 1'b0, 1'b1);
         both_views(32'h0000_0040, "R4_R9_R3");
      end
      // R6: priority saturation at both ends
      upd(32'h0000_0040, 1'b0, 1'b1);
      both_views(32'h0000_0040, "R6");
      for (int k = 0; k < 5; k++) begin
         upd(32'h0000_0040, 1'b0, 1'b0);
         both_views(32'h0000_0040, "R6");
      end

      // R5: background training never touches bit 2
      upd(32'h0000_0100, 1'b0, 1'b1);
      upd(32'h0000_0100, 1'b0, 1'b1);
      for (int k = 0; k < 3; k++) begin
         upd(32'h0000_0100, 1'b1, 1'b1);
         both_views(32'h0000_0100, "R5");
      end
      for (int k = 0; k < 5; k++) begin
         upd(32'h0000_0100, 1'b1, 1'b0);
         both_views(32'h0000_0100, "R5_R6");
      end

      // R2: aliasing through bits outside [9:2]
      upd(32'h0000_0203, 1'b0, 1'b1);
      upd(32'h8000_0601, 1'b0, 1'b1);
      look(32'hFFFF_FE00, 1'b0, "R2");
      look(32'h0000_0204, 1'b0, "R2");
      look(32'h0000_0200, 1'b1, "R2");

      // R7: strobe low leaves entry untouched
      for (int k = 0; k < 4; k++)
         cyc(32'h0000_0080, 1'b0, 1'b1, "R7", 1'b0, 32'h0000_0080, 1'b0, 1'b1);
      both_views(32'h0000_0080, "R7");
      upd(32'h0000_0080, 1'b1, 1'b1);
      look(32'h0000_0080, 1'b1, "R7");

      // R8: same-cycle lookup sees old state, next cycle sees new
      upd(32'h0000_0050, 1'b0, 1'b1);
      cyc(32'h0000_0050, 1'b0, 1'b1, "R8", 1'b1, 32'h0000_0050, 1'b0, 1'b1);
      look(32'h0000_0050, 1'b0, "R8");
      cyc(32'h0000_0050, 1'b1, 1'b1, "R8", 1'b1, 32'h0000_0050, 1'b1, 1'b0);
      look(32'h0000_0050, 1'b1, "R8");

      @(negedge clk);
      up_valid = 1'b0;
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule